// File: doc/BRIEF.md
# Octal DAC Parallel Write Sequencer

This controller sits on the host side of an eight-channel, 14-bit, parallel-input digital-to-analog converter. A request carries a channel number and a code. The block drives the converter's 3-bit channel address, chip select, write strobe and data bus, and holds each strobe for a whole number of clock cycles. Every cycle count is derived from a nanosecond minimum and the clock period. After a write it can raise an update strobe at once, which moves the latched code to the output. It can also leave the update for later, so that one standalone update request moves all eight channels together.

A clear request pulls the converter's clear line low for a set length. The block then waits out the analog settling interval before it accepts any further work. `busy` stays high for the whole of each operation, and `done` marks its last cycle. Requests that arrive while `busy` is high are dropped and are not queued.

Top module: `dac_wr_seq`

## Requirements
- R1: While reset is held, and after it is released, `dac_cs_n`, `dac_wr_n`, `dac_ldac_n` and `dac_clr_n` are high and `busy` and `done` are low.
- R2: A write drives `dac_addr` to the requested channel (channel n is binary n) and `dac_data` to the requested code. Both hold unchanged from the cycle `dac_cs_n` falls until it rises, so both are valid when `dac_wr_n` rises.
- R3: `dac_cs_n` falls at least SETUP_CYC = max(ceil(15/T), ceil(20/T)) cycles before `dac_wr_n` falls, where T is the clock period in ns (4 cycles at 5 ns).
- R4: `dac_wr_n` is low for exactly WR_CYC cycles, and only while `dac_cs_n` is low. WR_CYC = max(ceil(50/T), ceil(50/T) − SETUP_CYC − 1), which is 10 cycles at 5 ns.
- R5: `dac_cs_n` stays low for exactly one cycle after `dac_wr_n` rises.
- R6: With `req_update`=1, `dac_ldac_n` is low for LDAC_CYC = ceil(50/T) cycles (10), starting the cycle after `dac_cs_n` rises. With `req_update`=0, `dac_ldac_n` stays high.
- R7: `upd_req` in an idle cycle gives one LDAC_CYC pulse on `dac_ldac_n` with no chip-select activity.
- R8: `clr_req` drives `dac_clr_n` low for ceil(300/T) cycles (60). `busy` then stays high for ceil(31000/T) more cycles (6200), plus the `done` cycle. No bus strobe moves during that time.
- R9: `busy` is high from the cycle after a request is accepted through the single `done` cycle. A request made while `busy` is high has no effect.
- R10: When several requests arrive in the same idle cycle, `clr_req` wins over `req_valid`, and `req_valid` wins over `upd_req`. The losing requests are dropped.
- R11: Every interval lasts max(1, ceil(t/T)) cycles, and chip select is low for SETUP_CYC + WR_CYC + 1 cycles (15) per write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Write request, sampled when idle |
| req_chan | input | 3 | Channel to write |
| req_data | input | 14 | Code to write |
| req_update | input | 1 | Pulse the update strobe straight after this write |
| upd_req | input | 1 | Standalone update of all channels |
| clr_req | input | 1 | Clear the converter and wait for settling |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Last cycle of an operation |
| dac_addr | output | 3 | Converter channel address |
| dac_data | output | 14 | Converter data bus |
| dac_cs_n | output | 1 | Converter chip select, active low |
| dac_wr_n | output | 1 | Converter write strobe, active low |
| dac_ldac_n | output | 1 | Converter output update strobe, active low |
| dac_clr_n | output | 1 | Converter clear, active low |

## Verification
On every cycle the assertions check the ordering rules. The write strobe only falls and stays low inside chip select. The address and data stay fixed while chip select is low. The update and clear strobes never overlap a bus access. `done` is a single cycle inside `busy`. No state ends before its timer runs out. The exact pulse lengths, the setup and hold cycle counts, the update choice for each request, the request priority and the dropping of requests made while busy can only be shown by the bench. It counts cycles at the ports across a table of writes and a set of directed clear, update and collision scenarios.

// File: rtl/dac_seq_pkg.sv
`timescale 1ns/1ps
// Shared types and cycle arithmetic for the DAC write sequencer.
// Assumes every timing figure is a non-negative whole number of ns.
package dac_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SETUP, ST_STROBE, ST_RELEASE,
        ST_LDAC, ST_CLR, ST_SETTLE, ST_DONE
    } seq_state_t;

    // Cycles needed to cover t_ns at period_ns, never fewer than one.
    function automatic int cyc_of(input int t_ns, input int period_ns);
        int c;
        c = (t_ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dac_seq_timer.sv
`timescale 1ns/1ps
// Down counter that times one sequencer state.
// Loaded with (duration - 1) on state entry; zero marks the last cycle.
module dac_seq_timer #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt;

    // Load on state entry, otherwise count down and rest at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt <= '0;
        else if (load)      cnt <= load_val;
        else if (cnt != '0) cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && zero) |=> zero); // R11

endmodule

// File: rtl/dac_seq_fsm.sv
`timescale 1ns/1ps
// Operation sequencer: picks a request when idle and steps through the
// write, update, clear and settle phases, each timed by dac_seq_timer.
// Assumes the cycle counts are computed by the parent from ns figures.
module dac_seq_fsm
    import dac_seq_pkg::*;
#(
    parameter int CNT_W      = 13,
    parameter int SETUP_CYC  = 4,
    parameter int WR_CYC     = 10,
    parameter int HOLD_CYC   = 1,
    parameter int LDAC_CYC   = 10,
    parameter int CLR_CYC    = 60,
    parameter int SETTLE_CYC = 6200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_update,
    input  logic             upd_req,
    input  logic             clr_req,
    input  logic             tmr_zero,
    output seq_state_t       state_d,
    output logic             capture,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val
);
    seq_state_t state_q;
    logic       upd_q;

    // Next-state choice; clear beats write, and write beats update.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (clr_req)        state_d = ST_CLR;
                else if (req_valid) state_d = ST_SETUP;
                else if (upd_req)   state_d = ST_LDAC;
            end
            ST_SETUP:   if (tmr_zero) state_d = ST_STROBE;
            ST_STROBE:  if (tmr_zero) state_d = ST_RELEASE;
            ST_RELEASE: if (tmr_zero) state_d = upd_q ? ST_LDAC : ST_DONE;
            ST_LDAC:    if (tmr_zero) state_d = ST_DONE;
            ST_CLR:     if (tmr_zero) state_d = ST_SETTLE;
            ST_SETTLE:  if (tmr_zero) state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    assign capture  = (state_q == ST_IDLE) && (state_d == ST_SETUP);
    assign tmr_load = (state_d != state_q);

    // Duration of the state being entered, minus one.
    always_comb begin
        unique case (state_d)
            ST_SETUP:   tmr_val = CNT_W'(SETUP_CYC - 1);
            ST_STROBE:  tmr_val = CNT_W'(WR_CYC - 1);
            ST_RELEASE: tmr_val = CNT_W'(HOLD_CYC - 1);
            ST_LDAC:    tmr_val = CNT_W'(LDAC_CYC - 1);
            ST_CLR:     tmr_val = CNT_W'(CLR_CYC - 1);
            ST_SETTLE:  tmr_val = CNT_W'(SETTLE_CYC - 1);
            default:    tmr_val = '0;
        endcase
    end

    // State register and the update choice latched with the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            upd_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (capture) upd_q <= req_update;
        end
    end

    AST_LEAVE_ON_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && state_q != ST_DONE && state_d != state_q)
        |-> tmr_zero); // R11

    AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |=> (state_q == ST_IDLE)); // R9

endmodule

// File: rtl/dac_seq_drive.sv
`timescale 1ns/1ps
// Registered pin driver: turns the next sequencer state into glitch-free
// converter strobes and holds the captured address and code on the bus.
module dac_seq_drive
    import dac_seq_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_t        state_d,
    input  logic              capture,
    input  logic [ADDR_W-1:0] in_chan,
    input  logic [DATA_W-1:0] in_data,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] dac_addr,
    output logic [DATA_W-1:0] dac_data,
    output logic              dac_cs_n,
    output logic              dac_wr_n,
    output logic              dac_ldac_n,
    output logic              dac_clr_n
);
    // Strobe and handshake registers follow the state being entered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_cs_n   <= 1'b1;
            dac_wr_n   <= 1'b1;
            dac_ldac_n <= 1'b1;
            dac_clr_n  <= 1'b1;
            busy       <= 1'b0;
            done       <= 1'b0;
        end else begin
            dac_cs_n   <= !(state_d == ST_SETUP || state_d == ST_STROBE ||
                            state_d == ST_RELEASE);
            dac_wr_n   <= (state_d != ST_STROBE);
            dac_ldac_n <= (state_d != ST_LDAC);
            dac_clr_n  <= (state_d != ST_CLR);
            busy       <= (state_d != ST_IDLE);
            done       <= (state_d == ST_DONE);
        end
    end

    // Bus contents change only on a newly accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_addr <= '0;
            dac_data <= '0;
        end else if (capture) begin
            dac_addr <= in_chan;
            dac_data <= in_data;
        end
    end

    AST_WR_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_wr_n |-> !dac_cs_n); // R4
    AST_WR_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_wr_n) |-> $past(!dac_cs_n)); // R3
    AST_BUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!dac_cs_n && $past(!dac_cs_n)) |-> ($stable(dac_addr) && $stable(dac_data))); // R2
    AST_LDAC_APART: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_ldac_n |-> (dac_cs_n && dac_clr_n)); // R6
    AST_CLR_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_clr_n |-> (dac_cs_n && dac_ldac_n && busy)); // R8
    AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

endmodule

// File: rtl/dac_wr_seq.sv
`timescale 1ns/1ps
// Top of the octal DAC write sequencer. Converts the ns timing minimums
// into cycle counts at CLK_PERIOD_NS and wires sequencer, timer and driver.
// Assumes requests are synchronous to clk and held for at least one cycle.
module dac_wr_seq
    import dac_seq_pkg::*;
#(
    parameter int CLK_PERIOD_NS  = 5,
    parameter int ADDR_W         = 3,
    parameter int DATA_W         = 14,
    parameter int T_ADDR_SU_NS   = 15,
    parameter int T_DATA_SU_NS   = 20,
    parameter int T_CS_LOW_NS    = 50,
    parameter int T_WR_LOW_NS    = 50,
    parameter int T_HOLD_NS      = 0,
    parameter int T_LDAC_LOW_NS  = 50,
    parameter int T_CLR_LOW_NS   = 300,
    parameter int T_SETTLE_NS    = 31000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_chan,
    input  logic [DATA_W-1:0] req_data,
    input  logic              req_update,
    input  logic              upd_req,
    input  logic              clr_req,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] dac_addr,
    output logic [DATA_W-1:0] dac_data,
    output logic              dac_cs_n,
    output logic              dac_wr_n,
    output logic              dac_ldac_n,
    output logic              dac_clr_n
);
    localparam int SETUP_CYC  = max2(cyc_of(T_ADDR_SU_NS, CLK_PERIOD_NS),
                                     cyc_of(T_DATA_SU_NS, CLK_PERIOD_NS));
    localparam int HOLD_CYC   = cyc_of(T_HOLD_NS, CLK_PERIOD_NS);
    localparam int WR_CYC     = max2(cyc_of(T_WR_LOW_NS, CLK_PERIOD_NS),
                                     cyc_of(T_CS_LOW_NS, CLK_PERIOD_NS) - SETUP_CYC - HOLD_CYC);
    localparam int LDAC_CYC   = cyc_of(T_LDAC_LOW_NS, CLK_PERIOD_NS);
    localparam int CLR_CYC    = cyc_of(T_CLR_LOW_NS, CLK_PERIOD_NS);
    localparam int SETTLE_CYC = cyc_of(T_SETTLE_NS, CLK_PERIOD_NS);
    localparam int MAX_CYC    = max2(max2(max2(SETUP_CYC, WR_CYC), max2(LDAC_CYC, CLR_CYC)),
                                     max2(SETTLE_CYC, HOLD_CYC));
    localparam int CNT_W      = $clog2(MAX_CYC + 1);

    seq_state_t       state_d;
    logic             capture;
    logic             tmr_load;
    logic             tmr_zero;
    logic [CNT_W-1:0] tmr_val;

    dac_seq_fsm #(
        .CNT_W(CNT_W), .SETUP_CYC(SETUP_CYC), .WR_CYC(WR_CYC),
        .HOLD_CYC(HOLD_CYC), .LDAC_CYC(LDAC_CYC), .CLR_CYC(CLR_CYC),
        .SETTLE_CYC(SETTLE_CYC)
    ) i_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_update(req_update),
        .upd_req(upd_req), .clr_req(clr_req), .tmr_zero(tmr_zero),
        .state_d(state_d), .capture(capture), .tmr_load(tmr_load), .tmr_val(tmr_val)
    );

    dac_seq_timer #(.CNT_W(CNT_W)) i_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
    );

    dac_seq_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_drive (
        .clk(clk), .rst_n(rst_n), .state_d(state_d), .capture(capture),
        .in_chan(req_chan), .in_data(req_data), .busy(busy), .done(done),
        .dac_addr(dac_addr), .dac_data(dac_data), .dac_cs_n(dac_cs_n),
        .dac_wr_n(dac_wr_n), .dac_ldac_n(dac_ldac_n), .dac_clr_n(dac_clr_n)
    );

endmodule

// File: tb/test_dac_wr_seq.sv
`timescale 1ns/1ps
module test_dac_wr_seq;
    localparam int TP = 5;
    function automatic int cdiv(input int ns);
        int c;
        c = (ns + TP - 1) / TP;
        return (c < 1) ? 1 : c;
    endfunction
    localparam int E_SETUP  = (cdiv(15) > cdiv(20)) ? cdiv(15) : cdiv(20);
    localparam int E_WR     = cdiv(50);
    localparam int E_HOLD   = 1;
    localparam int E_LDAC   = cdiv(50);
    localparam int E_CLR    = cdiv(300);
    localparam int E_SETTLE = cdiv(31000);

    // vector: {update, chan[2:0], data[13:0]}
    localparam int NV = 6;
    localparam logic [17:0] VEC [NV] = '{
        {1'b1, 3'd0, 14'h0000}, {1'b0, 3'd7, 14'h3FFF}, {1'b1, 3'd3, 14'h1FFF},
        {1'b0, 3'd4, 14'h2000}, {1'b1, 3'd5, 14'h2AAA}, {1'b0, 3'd2, 14'h1555}
    };

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_update = 0, upd_req = 0, clr_req = 0;
    logic [2:0] req_chan = 0;
    logic [13:0] req_data = 0;
    logic busy, done, dac_cs_n, dac_wr_n, dac_ldac_n, dac_clr_n;
    logic [2:0] dac_addr;
    logic [13:0] dac_data;
    int n_chk = 0, n_fail = 0;
    int m_cs, m_wr, m_setup, m_hold, m_ldac, m_clr, m_busy, m_addr, m_data;

    always #2.5 clk = ~clk;

    dac_wr_seq i_dac_wr_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chan(req_chan),
        .req_data(req_data), .req_update(req_update), .upd_req(upd_req),
        .clr_req(clr_req), .busy(busy), .done(done), .dac_addr(dac_addr),
        .dac_data(dac_data), .dac_cs_n(dac_cs_n), .dac_wr_n(dac_wr_n),
        .dac_ldac_n(dac_ldac_n), .dac_clr_n(dac_clr_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Issue one set of requests, then measure the operation at the pins.
    task automatic run_op(input logic wv, input logic uv, input logic ov, input logic cv,
                          input logic [2:0] ch, input logic [13:0] dt, input int inj);
        bit seen_wr;
        @(negedge clk);
        req_valid = wv; req_update = uv; upd_req = ov; clr_req = cv;
        req_chan = ch; req_data = dt;
        @(negedge clk);
        req_valid = 0; req_update = 0; upd_req = 0; clr_req = 0;
        m_cs = 0; m_wr = 0; m_setup = 0; m_hold = 0; m_ldac = 0; m_clr = 0; m_busy = 0;
        m_addr = -1; m_data = -1; seen_wr = 0;
        for (int c = 0; c < 20000; c++) begin
            if (busy) m_busy++;
            if (!dac_cs_n) m_cs++;
            if (!dac_wr_n) begin m_wr++; seen_wr = 1; m_addr = dac_addr; m_data = dac_data; end
            if (!dac_cs_n && dac_wr_n && !seen_wr) m_setup++;
            if (!dac_cs_n && dac_wr_n && seen_wr) m_hold++;
            if (!dac_ldac_n) m_ldac++;
            if (!dac_clr_n) m_clr++;
            if (done) break;
            @(negedge clk);
            req_valid = (c + 1 == inj) && inj > 0;
            req_chan = 3'd6; req_data = 14'h0ABC;
            clr_req = (c + 1 == inj) && inj > 0;
        end
        req_valid = 0; clr_req = 0;
    endtask

    // Confirm nothing starts in the cycles after an operation (dropped requests).
    task automatic quiet_after(input string req);
        bit moved = 0;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            if (busy || !dac_cs_n || !dac_clr_n || !dac_ldac_n) moved = 1;
        end
        check(!moved, req, moved, 0);
    endtask

    initial begin
        #(TP * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values while reset is held
        check(dac_cs_n && dac_wr_n && dac_ldac_n && dac_clr_n && !busy && !done,
              "R1 reset outputs", {busy, done}, 0);
        rst_n = 1;
        @(negedge clk);
        check(dac_cs_n && dac_wr_n && dac_ldac_n && dac_clr_n && !busy && !done,
              "R1 idle after reset", {busy, done}, 0);

        // table of writes
        for (int v = 0; v < NV; v++) begin
            run_op(1'b1, VEC[v][17], 1'b0, 1'b0, VEC[v][16:14], VEC[v][13:0], 0);
            check(m_addr == int'(VEC[v][16:14]), "R2 address at write edge", m_addr, VEC[v][16:14]);
            check(m_data == int'(VEC[v][13:0]), "R2 data at write edge", m_data, VEC[v][13:0]);
            check(m_setup == E_SETUP, "R3 cs-to-wr setup", m_setup, E_SETUP);
            check(m_wr == E_WR, "R4 wr low length", m_wr, E_WR);
            check(m_hold == E_HOLD, "R5 cs hold after wr", m_hold, E_HOLD);
            check(m_ldac == (VEC[v][17] ? E_LDAC : 0), "R6 update choice", m_ldac,
                  VEC[v][17] ? E_LDAC : 0);
            check(m_cs == E_SETUP + E_WR + E_HOLD, "R11 cs low length", m_cs,
                  E_SETUP + E_WR + E_HOLD);
            check(m_busy == E_SETUP + E_WR + E_HOLD + (VEC[v][17] ? E_LDAC : 0) + 1,
                  "R9 busy span", m_busy, E_SETUP + E_WR + E_HOLD + (VEC[v][17] ? E_LDAC : 0) + 1);
        end

        // R7: standalone update of all channels
        run_op(1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 14'd0, 0);
        check(m_ldac == E_LDAC, "R7 standalone ldac length", m_ldac, E_LDAC);
        check(m_cs == 0, "R7 no cs on update", m_cs, 0);
        check(m_busy == E_LDAC + 1, "R7 busy span", m_busy, E_LDAC + 1);

        // R8: clear, with requests injected during the settling wait
        run_op(1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 14'd0, 200);
        check(m_clr == E_CLR, "R8 clear pulse length", m_clr, E_CLR);
        check(m_busy == E_CLR + E_SETTLE + 1, "R8 busy through settling", m_busy,
              E_CLR + E_SETTLE + 1);
        check(m_cs == 0 && m_ldac == 0, "R8 no strobes during clear", m_cs + m_ldac, 0);
        quiet_after("R8 injected request dropped");

        // R9: write request during an active write is dropped
        run_op(1'b1, 1'b0, 1'b0, 1'b0, 3'd1, 14'h0123, 5);
        check(m_addr == 1 && m_data == 14'h0123, "R9 bus unaffected by busy request",
              m_addr, 1);
        check(m_clr == 0, "R9 clear during busy dropped", m_clr, 0);
        quiet_after("R9 busy request not queued");

        // R10: clear beats write
        run_op(1'b1, 1'b1, 1'b0, 1'b1, 3'd5, 14'h0777, 0);
        check(m_clr == E_CLR && m_cs == 0, "R10 clear wins over write", m_cs, 0);
        // R10: write beats update
        run_op(1'b1, 1'b0, 1'b1, 1'b0, 3'd6, 14'h0444, 0);
        check(m_cs == E_SETUP + E_WR + E_HOLD && m_ldac == 0, "R10 write wins over update",
              m_ldac, 0);
        quiet_after("R10 losing update dropped");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule